// File: doc/BRIEF.md
# Byte-to-Command Word Assembler

This block sits behind a pipelined bus slave port that carries 8-bit message bytes. It collects three consecutive byte beats into one 24-bit command word and hands each finished word to a downstream command queue through a one-cycle write strobe and a data bus. A full flag from the queue holds the slave port off while a finished word cannot be delivered.

A four-state machine tracks the byte phase. `ST_IDLE` waits for the first byte. An accepted beat moves it to `ST_HAVE1`, then to `ST_HAVE2`, then to `ST_HAVE3`, where the word is complete. From `ST_HAVE1` or `ST_HAVE2`, a low cycle signal aborts the partial word, goes back to `ST_IDLE` and pulses the error output. From `ST_HAVE3` the word is written as soon as the queue is not full. The machine then goes to `ST_IDLE`, or straight to `ST_HAVE1` if a new first byte is accepted in that same cycle. While the queue is full, `ST_HAVE3` holds and stalls the port.

The address and tag inputs are carried on the port for bus compatibility but play no part in assembly.

Top module: `byte_opcode_asm`

## Requirements
- R1: While reset is high, and in the first cycle after it, ack, err, stall and the write strobe are low, and the machine is in `ST_IDLE`.
- R2: A beat is accepted only when cyc and stb are both high and stall is low. ack is high in exactly the cycle after each accepted beat and low otherwise.
- R3: The first byte of a word lands in bits [23:16] of the write data, the second in [15:8] and the third in [7:0].
- R4: The write strobe is a single-cycle pulse. It is raised in the cycle after the third byte is accepted when full is low. There is exactly one write per three accepted bytes.
- R5: Stall is high exactly when a completed word is waiting and full is high. While stalled, no beat is accepted, ack stays low and the write data holds its value.
- R6: When full falls while a completed word waits, stall drops and the write strobe rises in that same cycle.
- R7: If cyc is low while one or two bytes of a word are held, that partial word is dropped, err is high for one cycle in the following cycle, and no write occurs. The next accepted byte starts a new word.
- R8: In the cycle a completed word is written, a new first byte may be accepted. It becomes bits [23:16] of the next word.
- R9: cyc going low while a completed word waits raises no err, and the word is still written once full is low.
- R10: The address and tag inputs have no effect on ack, stall, err or the written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wbs_cyc_i | input | 1 | Bus cycle active |
| wbs_stb_i | input | 1 | Beat strobe |
| wbs_adr_i | input | 10 | Beat address (not used in assembly) |
| wbs_tga_i | input | 10 | Beat address tag (not used in assembly) |
| wbs_dat_i | input | 8 | Message byte |
| wbs_ack_o | output | 1 | Acknowledge, one cycle after an accepted beat |
| wbs_stall_o | output | 1 | Beat not accepted this cycle |
| wbs_err_o | output | 1 | One-cycle pulse after a partial word is aborted |
| cmd_full_i | input | 1 | Downstream queue cannot take a word |
| cmd_wr_en_o | output | 1 | One-cycle write strobe into the queue |
| cmd_wr_data_o | output | 24 | Assembled command word |

## Verification
Two functions can fall in the same cycle: the write of a completed word and the acceptance of the next word's first byte. The bench provokes this by keeping stb high with a new byte in the cycle where the strobe rises. It does this both directly after the third byte and at the moment full is released after a stall. It judges the result from the written data of that word and of the next one, and by requiring ack in the following cycle. The sweep runs every byte value through each lane position with varying address and tag values, and computes each expected word from the byte order.

// File: rtl/bopasm_pkg.sv
package bopasm_pkg;
    localparam int BEATS = 3;
    localparam int LANE_FIRST  = BEATS - 1;
    localparam int LANE_SECOND = BEATS - 2;
    localparam int LANE_THIRD  = BEATS - 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HAVE1,
        ST_HAVE2,
        ST_HAVE3
    } asm_state_t;
endpackage

// File: rtl/bopasm_fsm.sv
module bopasm_fsm
    import bopasm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic             full_i,
    output logic             stall_o,
    output logic             accept_o,
    output logic             commit_o,
    output logic             abort_o,
    output logic [BEATS-1:0] lane_ld_o
);
    asm_state_t state, state_nx;
    logic       req;

    assign req      = cyc_i && stb_i;
    assign stall_o  = (state == ST_HAVE3) && full_i;
    assign accept_o = req && !stall_o;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        commit_o  = 1'b0;
        abort_o   = 1'b0;
        lane_ld_o = '0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    lane_ld_o[LANE_FIRST] = 1'b1;
                    state_nx = ST_HAVE1;
                end
            end
            ST_HAVE1: begin
                if (!cyc_i) begin
                    abort_o  = 1'b1;
                    state_nx = ST_IDLE;
                end else if (req) begin
                    lane_ld_o[LANE_SECOND] = 1'b1;
                    state_nx = ST_HAVE2;
                end
            end
            ST_HAVE2: begin
                if (!cyc_i) begin
                    abort_o  = 1'b1;
                    state_nx = ST_IDLE;
                end else if (req) begin
                    lane_ld_o[LANE_THIRD] = 1'b1;
                    state_nx = ST_HAVE3;
                end
            end
            ST_HAVE3: begin
                if (!full_i) begin
                    commit_o = 1'b1;
                    if (req) begin
                        lane_ld_o[LANE_FIRST] = 1'b1;
                        state_nx = ST_HAVE1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bopasm_lanes.sv
module bopasm_lanes
    import bopasm_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = BYTE_W * BEATS
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [BEATS-1:0]  lane_ld_i,
    input  logic [BYTE_W-1:0] dat_i,
    output logic [WORD_W-1:0] word_o
);
    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)               word_o[g*BYTE_W +: BYTE_W] <= '0;
            else if (lane_ld_i[g]) word_o[g*BYTE_W +: BYTE_W] <= dat_i;
        end
    end
endmodule

// File: rtl/bopasm_resp.sv
module bopasm_resp (
    input  logic clk,
    input  logic rst,
    input  logic accept_i,
    input  logic abort_i,
    output logic ack_o,
    output logic err_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o <= 1'b0;
            err_o <= 1'b0;
        end else begin
            ack_o <= accept_i;
            err_o <= abort_i;
        end
    end
endmodule

// File: rtl/byte_opcode_asm.sv
module byte_opcode_asm
    import bopasm_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADR_W  = 10,
    parameter int TGA_W  = 10,
    localparam int WORD_W = BYTE_W * BEATS
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wbs_cyc_i,
    input  logic              wbs_stb_i,
    input  logic [ADR_W-1:0]  wbs_adr_i,
    input  logic [TGA_W-1:0]  wbs_tga_i,
    input  logic [BYTE_W-1:0] wbs_dat_i,
    output logic              wbs_ack_o,
    output logic              wbs_stall_o,
    output logic              wbs_err_o,
    input  logic              cmd_full_i,
    output logic              cmd_wr_en_o,
    output logic [WORD_W-1:0] cmd_wr_data_o
);
    logic             accept;
    logic             abort;
    logic [BEATS-1:0] lane_ld;
    logic             unused_sideband;

    assign unused_sideband = ^{wbs_adr_i, wbs_tga_i};

    bopasm_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cyc_i     (wbs_cyc_i),
        .stb_i     (wbs_stb_i),
        .full_i    (cmd_full_i),
        .stall_o   (wbs_stall_o),
        .accept_o  (accept),
        .commit_o  (cmd_wr_en_o),
        .abort_o   (abort),
        .lane_ld_o (lane_ld)
    );

    bopasm_lanes #(.BYTE_W(BYTE_W)) u_lanes (
        .clk       (clk),
        .rst       (rst),
        .lane_ld_i (lane_ld),
        .dat_i     (wbs_dat_i),
        .word_o    (cmd_wr_data_o)
    );

    bopasm_resp u_resp (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .abort_i  (abort),
        .ack_o    (wbs_ack_o),
        .err_o    (wbs_err_o)
    );
endmodule

// File: rtl/byte_opcode_asm_chk.sv
module byte_opcode_asm_chk #(
    parameter int WORD_W = 24
)(
    input logic              clk,
    input logic              rst,
    input logic              wbs_cyc_i,
    input logic              wbs_stb_i,
    input logic              wbs_ack_o,
    input logic              wbs_stall_o,
    input logic              wbs_err_o,
    input logic              cmd_full_i,
    input logic              cmd_wr_en_o,
    input logic [WORD_W-1:0] cmd_wr_data_o
);
    logic beat;
    assign beat = wbs_cyc_i && wbs_stb_i && !wbs_stall_o;

    assert_ack_follows_beat_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && beat) |=> wbs_ack_o);

    assert_no_ack_without_beat_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && !beat) |=> !wbs_ack_o);

    assert_write_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && cmd_wr_en_o) |=> !cmd_wr_en_o);

    assert_no_write_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_wr_en_o |-> !cmd_full_i);

    assert_stall_needs_full_R5: assert property (@(posedge clk) disable iff (rst)
        wbs_stall_o |-> cmd_full_i);

    assert_data_held_in_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && wbs_stall_o) |=> $stable(cmd_wr_data_o));

    assert_err_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && wbs_err_o) |=> !wbs_err_o);

    assert_no_write_with_err_R7: assert property (@(posedge clk) disable iff (rst)
        wbs_err_o |-> !cmd_wr_en_o);
endmodule

bind byte_opcode_asm byte_opcode_asm_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wbs_cyc_i     (wbs_cyc_i),
    .wbs_stb_i     (wbs_stb_i),
    .wbs_ack_o     (wbs_ack_o),
    .wbs_stall_o   (wbs_stall_o),
    .wbs_err_o     (wbs_err_o),
    .cmd_full_i    (cmd_full_i),
    .cmd_wr_en_o   (cmd_wr_en_o),
    .cmd_wr_data_o (cmd_wr_data_o)
);

// File: tb/byte_opcode_asm_bench.sv
`timescale 1ns/1ps
module byte_opcode_asm_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0;
    logic        stb = 1'b0;
    logic [9:0]  adr = '0;
    logic [9:0]  tga = '0;
    logic [7:0]  dat = '0;
    logic        full = 1'b0;
    logic        ack, stall, err, wr_en;
    logic [23:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_opcode_asm u_byte_opcode_asm (
        .clk           (clk),
        .rst           (rst),
        .wbs_cyc_i     (cyc),
        .wbs_stb_i     (stb),
        .wbs_adr_i     (adr),
        .wbs_tga_i     (tga),
        .wbs_dat_i     (dat),
        .wbs_ack_o     (ack),
        .wbs_stall_o   (stall),
        .wbs_err_o     (err),
        .cmd_full_i    (full),
        .cmd_wr_en_o   (wr_en),
        .cmd_wr_data_o (wr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic nb();
        @(negedge clk);
        #1;
    endtask

    task automatic drive(input logic c, input logic s, input logic [7:0] d);
        cyc = c;
        stb = s;
        dat = d;
    endtask

    // First two bytes of a word, starting from the idle state.
    task automatic two_bytes(input logic [7:0] b0, input logic [7:0] b1, input string req);
        drive(1, 1, b0);
        nb();
        chk({req, " ack b0"}, ack, 1);
        drive(1, 1, b1);
        nb();
        chk({req, " ack b1"}, ack, 1);
    endtask

    // Whole word with full low; bus idle afterwards.
    task automatic word_plain(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                              input string req);
        two_bytes(b0, b1, req);
        drive(1, 1, b2);
        nb();
        chk({req, " R2 ack b2"}, ack, 1);
        chk({req, " R4 write"}, wr_en, 1);
        chk({req, " R3 word"}, wr_data, {b0, b1, b2});
        drive(0, 0, 8'h00);
        nb();
        chk({req, " R4 pulse end"}, wr_en, 0);
        chk({req, " R2 no ack"}, ack, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs
        drive(1, 1, 8'hA5);
        full = 1'b1;
        nb();
        nb();
        chk("R1 ack", ack, 0);
        chk("R1 err", err, 0);
        chk("R1 stall", stall, 0);
        chk("R1 wr_en", wr_en, 0);
        drive(0, 0, 8'h00);
        full = 1'b0;
        rst = 1'b0;
        nb();
        chk("R1 ack after", ack, 0);
        chk("R1 err after", err, 0);
        chk("R1 wr_en after", wr_en, 0);

        // R2: stb without cyc, cyc without stb
        drive(0, 1, 8'h11);
        nb();
        nb();
        chk("R2 no ack stb only", ack, 0);
        drive(1, 0, 8'h22);
        nb();
        nb();
        chk("R2 no ack cyc only", ack, 0);
        chk("R7 no err idle", err, 0);
        drive(0, 0, 8'h00);
        nb();
        word_plain(8'h12, 8'h34, 8'h56, "R2 R3 after idle junk");

        // R3 R4 R10: sweep of byte values with varying sideband
        for (int i = 0; i < 256; i++) begin
            adr = 10'((i * 13) & 1023);
            tga = 10'((i * 101 + 7) & 1023);
            word_plain(8'(i), 8'((i * 7 + 3) & 255), 8'(255 - i), "R10 sweep");
        end

        // R8: back-to-back words, commit and first byte share a cycle
        two_bytes(8'hA1, 8'hA2, "R8");
        drive(1, 1, 8'hA3);
        nb();
        chk("R8 write A", wr_en, 1);
        chk("R8 word A", wr_data, 24'hA1A2A3);
        drive(1, 1, 8'hB1);
        nb();
        chk("R8 ack B1", ack, 1);
        chk("R8 no write", wr_en, 0);
        drive(1, 1, 8'hB2);
        nb();
        chk("R8 ack B2", ack, 1);
        drive(1, 1, 8'hB3);
        nb();
        chk("R8 write B", wr_en, 1);
        chk("R8 word B", wr_data, 24'hB1B2B3);
        drive(0, 0, 8'h00);
        nb();

        // R5 R6: stall while full, release with a waiting byte
        full = 1'b1;
        #1;
        two_bytes(8'hC1, 8'hC2, "R5");
        chk("R5 no stall partial", stall, 0);
        drive(1, 1, 8'hC3);
        nb();
        chk("R5 ack C3", ack, 1);
        chk("R5 stall", stall, 1);
        chk("R5 no write full", wr_en, 0);
        drive(1, 1, 8'hD1);
        for (int k = 0; k < 3; k++) begin
            nb();
            chk("R5 stalled no ack", ack, 0);
            chk("R5 stall held", stall, 1);
            chk("R5 data held", wr_data, 24'hC1C2C3);
        end
        full = 1'b0;
        #1;
        chk("R6 stall drops", stall, 0);
        chk("R6 write on release", wr_en, 1);
        chk("R6 word", wr_data, 24'hC1C2C3);
        nb();
        chk("R8 ack D1 at release", ack, 1);
        chk("R4 pulse once", wr_en, 0);
        drive(1, 1, 8'hD2);
        nb();
        drive(1, 1, 8'hD3);
        nb();
        chk("R8 word D", wr_data, 24'hD1D2D3);
        chk("R4 write D", wr_en, 1);
        drive(0, 0, 8'h00);
        nb();

        // R7: abort after one byte
        drive(1, 1, 8'hE1);
        nb();
        chk("R7 ack E1", ack, 1);
        drive(0, 0, 8'h00);
        nb();
        chk("R7 err pulse 1", err, 1);
        chk("R7 no write 1", wr_en, 0);
        nb();
        chk("R7 err end 1", err, 0);
        word_plain(8'h71, 8'h72, 8'h73, "R7 after abort1");

        // R7: abort after two bytes
        two_bytes(8'hF1, 8'hF2, "R7");
        drive(0, 0, 8'h00);
        nb();
        chk("R7 err pulse 2", err, 1);
        chk("R7 no write 2", wr_en, 0);
        nb();
        chk("R7 err end 2", err, 0);
        chk("R7 no write later", wr_en, 0);
        word_plain(8'h81, 8'h82, 8'h83, "R7 after abort2");

        // R9: cyc drops while a complete word waits
        full = 1'b1;
        #1;
        two_bytes(8'h91, 8'h92, "R9");
        drive(1, 1, 8'h93);
        nb();
        chk("R9 stall", stall, 1);
        drive(0, 0, 8'h00);
        nb();
        chk("R9 no err", err, 0);
        nb();
        chk("R9 no err later", err, 0);
        full = 1'b0;
        #1;
        chk("R9 write", wr_en, 1);
        chk("R9 word", wr_data, 24'h919293);
        nb();
        chk("R9 pulse end", wr_en, 0);
        chk("R9 no err end", err, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule